// File: doc/BRIEF.md
# Clock Stop and Power-Down Gate

This block sits after the clock generators of a system clock chip and decides, cycle by cycle, which generated clocks reach the pins. It receives running internal clocks for five domains: a differential CPU pair group, a PCI group, a graphics-port group, a reference group and a fixed-frequency group. It passes each clock through a per-output gate. The PCI domain also feeds one free-running PCI output.

Three asynchronous active-low requests control the gates. The CPU stop request parks the CPU pairs. The PCI stop request parks the gated PCI outputs. The power-down request parks everything, including the free-running PCI output. A per-output enable vector, taken from a configuration register, forces single outputs inactive. Every gate is driven by a synchronizer that runs on the falling edge of its own clock. A gate therefore opens or closes only while its clock is low, so no output ever carries a shortened pulse.

Top module: `clk_stop_gate`

## Requirements
- R1: While rst_ni is low, every CPU true output, PCI, free-running PCI, graphics, reference and fixed output is low, and every CPU complement output is high.
- R2: Each output's run condition is its enable bit, AND its group's stop input high (if the group has one), AND pd_ni high. It is sampled on every falling edge of the output's clock. The value sampled at falling edge k controls the output from falling edge k+1 until falling edge k+2. While gated on, the output equals its clock; while gated off, it is low.
- R3: Every high pulse on a gated output is exactly half a clock period wide. A stop or restart never shortens a pulse.
- R4: After cpu_stop_ni falls, a CPU true output gives at most one more high pulse, then stays low while its complement stays high. After cpu_stop_ni rises, the first high pulse of the true output comes on the second rising edge. Both latencies are under 4 CPU cycles.
- R5: Each CPU complement output is always the inverse of its true output, whether running, stopped or disabled.
- R6: After pci_stop_ni falls, a gated PCI output gives at most one more high pulse and then stays low. After pci_stop_ni rises, its first high pulse comes on the second rising PCI edge.
- R7: The free-running PCI output, graphics, reference and fixed outputs are unaffected by cpu_stop_ni and pci_stop_ni.
- R8: cpu_stop_ni has no effect on the PCI outputs, and pci_stop_ni has no effect on the CPU outputs.
- R9: While pd_ni is low, every output parks in its R1 state within two falling edges of its own clock. The free-running PCI output is included.
- R10: An enable bit of 0 parks only its own output. Bit i of cpu_en_i controls CPU pair i, bit i of pci_en_i controls PCI output i, and the same holds for agp_en_i, ref_en_i and fix_en_i.
- R11: During power-down, changes on the stop inputs and enable bits have no effect at the outputs. When pd_ni rises, each output resumes according to its own stop input and enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_clk_i | input | 1 | Running internal CPU clock |
| pci_clk_i | input | 1 | Running internal PCI clock |
| agp_clk_i | input | 1 | Running internal graphics-port clock |
| ref_clk_i | input | 1 | Running reference clock |
| fix_clk_i | input | 1 | Running fixed-frequency clock |
| cpu_stop_ni | input | 1 | Asynchronous CPU stop request, active low |
| pci_stop_ni | input | 1 | Asynchronous PCI stop request, active low |
| pd_ni | input | 1 | Asynchronous power-down request, active low |
| cpu_en_i | input | N_CPU | Per-pair CPU enable |
| pci_en_i | input | N_PCI | Per-output PCI enable |
| agp_en_i | input | N_AGP | Per-output graphics-port enable |
| ref_en_i | input | N_REF | Per-output reference enable |
| fix_en_i | input | N_FIX | Per-output fixed-clock enable |
| cpu_t_o | output | N_CPU | CPU true outputs, park low |
| cpu_c_o | output | N_CPU | CPU complement outputs, park high |
| pci_o | output | N_PCI | Gated PCI outputs |
| pci_free_o | output | 1 | Free-running PCI output |
| agp_o | output | N_AGP | Graphics-port outputs |
| ref_o | output | N_REF | Reference outputs |
| fix_o | output | N_FIX | Fixed-frequency outputs |

## Verification
The assertions check the synchronizer contract on every falling edge of every gate. A request or enable that has been low for two consecutive falling edges must close the gate. A run condition that has been high for two must open it.

Only the bench's scenarios can show the following: the exact pulse counts after a stop or restart, the full width of each pulse, the isolation between groups, and that stop and enable changes are ignored during power-down. The bench shows these by comparing every output in both clock phases against a queue-based model and by timing the pulse widths.

// File: rtl/clk_stop_gate_pkg.sv
package clk_stop_gate_pkg;
  // falling-edge flops between an async request and its gate
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/csg_sync.sv
module csg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/csg_cell.sv
module csg_cell #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_ni,
  input  logic pd_ni,
  input  logic en_i,
  output logic clk_o
);
  logic run;
  logic gate_q;

  assign run = en_i & stop_ni & pd_ni;

  csg_sync #(.STAGES(STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (run),
    .q_o    (gate_q)
  );

  // gate only moves on the falling edge, so high phases pass whole
  assign clk_o = clk_i & gate_q;

  if (STAGES == 2) begin : g_chk
    // R9
    pd_off_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (!pd_ni && $past(!pd_ni)) |=> !gate_q);
    // R4 R6
    stop_off_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (!stop_ni && $past(!stop_ni)) |=> !gate_q);
    // R10
    en_off_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (!en_i && $past(!en_i)) |=> !gate_q);
    // R2
    run_on_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (run && $past(run) && $past(rst_ni)) |=> gate_q);
  end
endmodule

// File: rtl/csg_group.sv
module csg_group #(
  parameter int unsigned N      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stop_ni,
  input  logic         pd_ni,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] clk_o
);
  for (genvar i = 0; i < N; i++) begin : g_out
    csg_cell #(.STAGES(STAGES)) i_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .stop_ni (stop_ni),
      .pd_ni   (pd_ni),
      .en_i    (en_i[i]),
      .clk_o   (clk_o[i])
    );
  end
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
  import clk_stop_gate_pkg::*;
#(
  parameter int unsigned N_CPU  = 3,
  parameter int unsigned N_PCI  = 7,
  parameter int unsigned N_AGP  = 2,
  parameter int unsigned N_REF  = 2,
  parameter int unsigned N_FIX  = 2,
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic             rst_ni,
  input  logic             cpu_clk_i,
  input  logic             pci_clk_i,
  input  logic             agp_clk_i,
  input  logic             ref_clk_i,
  input  logic             fix_clk_i,
  input  logic             cpu_stop_ni,
  input  logic             pci_stop_ni,
  input  logic             pd_ni,
  input  logic [N_CPU-1:0] cpu_en_i,
  input  logic [N_PCI-1:0] pci_en_i,
  input  logic [N_AGP-1:0] agp_en_i,
  input  logic [N_REF-1:0] ref_en_i,
  input  logic [N_FIX-1:0] fix_en_i,
  output logic [N_CPU-1:0] cpu_t_o,
  output logic [N_CPU-1:0] cpu_c_o,
  output logic [N_PCI-1:0] pci_o,
  output logic             pci_free_o,
  output logic [N_AGP-1:0] agp_o,
  output logic [N_REF-1:0] ref_o,
  output logic [N_FIX-1:0] fix_o
);
  csg_group #(.N(N_CPU), .STAGES(STAGES)) i_cpu (
    .clk_i(cpu_clk_i), .rst_ni(rst_ni), .stop_ni(cpu_stop_ni), .pd_ni(pd_ni),
    .en_i(cpu_en_i), .clk_o(cpu_t_o)
  );

  // complement parks high because the true side parks low
  assign cpu_c_o = ~cpu_t_o;

  csg_group #(.N(N_PCI), .STAGES(STAGES)) i_pci (
    .clk_i(pci_clk_i), .rst_ni(rst_ni), .stop_ni(pci_stop_ni), .pd_ni(pd_ni),
    .en_i(pci_en_i), .clk_o(pci_o)
  );

  csg_group #(.N(1), .STAGES(STAGES)) i_pci_free (
    .clk_i(pci_clk_i), .rst_ni(rst_ni), .stop_ni(1'b1), .pd_ni(pd_ni),
    .en_i(1'b1), .clk_o(pci_free_o)
  );

  csg_group #(.N(N_AGP), .STAGES(STAGES)) i_agp (
    .clk_i(agp_clk_i), .rst_ni(rst_ni), .stop_ni(1'b1), .pd_ni(pd_ni),
    .en_i(agp_en_i), .clk_o(agp_o)
  );

  csg_group #(.N(N_REF), .STAGES(STAGES)) i_ref (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .stop_ni(1'b1), .pd_ni(pd_ni),
    .en_i(ref_en_i), .clk_o(ref_o)
  );

  csg_group #(.N(N_FIX), .STAGES(STAGES)) i_fix (
    .clk_i(fix_clk_i), .rst_ni(rst_ni), .stop_ni(1'b1), .pd_ni(pd_ni),
    .en_i(fix_en_i), .clk_o(fix_o)
  );
endmodule

// File: tb/test_clk_stop_gate.sv
`timescale 1ns/1ps
module test_clk_stop_gate;
  localparam int CLK_PERIOD = 12;
  localparam int CPU_P = CLK_PERIOD;
  localparam int AGP_P = 2 * CLK_PERIOD;
  localparam int PCI_P = 4 * CLK_PERIOD;
  localparam int FIX_P = 40;
  localparam int REF_P = 80;
  localparam int WATCHDOG = 200000;
  localparam int N_CPU = 3, N_PCI = 7, N_AGP = 2, N_REF = 2, N_FIX = 2;

  logic rst_ni = 1'b0;
  logic cpu_clk = 1'b0, pci_clk = 1'b0, agp_clk = 1'b0, ref_clk = 1'b0, fix_clk = 1'b0;
  logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pd_n = 1'b1;
  logic [N_CPU-1:0] cpu_en = '1;
  logic [N_PCI-1:0] pci_en = '1;
  logic [N_AGP-1:0] agp_en = '1;
  logic [N_REF-1:0] ref_en = '1;
  logic [N_FIX-1:0] fix_en = '1;
  logic [N_CPU-1:0] cpu_t, cpu_c;
  logic [N_PCI-1:0] pci_o;
  logic             pci_free;
  logic [N_AGP-1:0] agp_o;
  logic [N_REF-1:0] ref_o;
  logic [N_FIX-1:0] fix_o;

  always #(CPU_P/2) cpu_clk = ~cpu_clk;
  always #(PCI_P/2) pci_clk = ~pci_clk;
  always #(AGP_P/2) agp_clk = ~agp_clk;
  always #(REF_P/2) ref_clk = ~ref_clk;
  always #(FIX_P/2) fix_clk = ~fix_clk;

  clk_stop_gate i_clk_stop_gate (
    .rst_ni(rst_ni), .cpu_clk_i(cpu_clk), .pci_clk_i(pci_clk), .agp_clk_i(agp_clk),
    .ref_clk_i(ref_clk), .fix_clk_i(fix_clk), .cpu_stop_ni(cpu_stop_n),
    .pci_stop_ni(pci_stop_n), .pd_ni(pd_n), .cpu_en_i(cpu_en), .pci_en_i(pci_en),
    .agp_en_i(agp_en), .ref_en_i(ref_en), .fix_en_i(fix_en), .cpu_t_o(cpu_t),
    .cpu_c_o(cpu_c), .pci_o(pci_o), .pci_free_o(pci_free), .agp_o(agp_o),
    .ref_o(ref_o), .fix_o(fix_o)
  );

  int checks = 0;
  int errors = 0;
  string req_tag = "R1";

  function automatic void check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
    end
  endfunction

  // model: run condition seen at each falling edge; gate = value from one edge before the last
  logic [N_CPU-1:0] cpu_hist[$];
  logic [N_PCI-1:0] pci_hist[$];
  logic             pcf_hist[$];
  logic [N_AGP-1:0] agp_hist[$];
  logic [N_REF-1:0] ref_hist[$];
  logic [N_FIX-1:0] fix_hist[$];
  logic [N_CPU-1:0] cpu_g;
  logic [N_PCI-1:0] pci_g;
  logic             pcf_g;
  logic [N_AGP-1:0] agp_g;
  logic [N_REF-1:0] ref_g;
  logic [N_FIX-1:0] fix_g;

  always @(negedge cpu_clk or negedge rst_ni)
    if (!rst_ni) cpu_hist.delete();
    else cpu_hist.push_back(cpu_en & {N_CPU{cpu_stop_n & pd_n}});
  always @(negedge pci_clk or negedge rst_ni)
    if (!rst_ni) begin pci_hist.delete(); pcf_hist.delete(); end
    else begin
      pci_hist.push_back(pci_en & {N_PCI{pci_stop_n & pd_n}});
      pcf_hist.push_back(pd_n);
    end
  always @(negedge agp_clk or negedge rst_ni)
    if (!rst_ni) agp_hist.delete(); else agp_hist.push_back(agp_en & {N_AGP{pd_n}});
  always @(negedge ref_clk or negedge rst_ni)
    if (!rst_ni) ref_hist.delete(); else ref_hist.push_back(ref_en & {N_REF{pd_n}});
  always @(negedge fix_clk or negedge rst_ni)
    if (!rst_ni) fix_hist.delete(); else fix_hist.push_back(fix_en & {N_FIX{pd_n}});

  // high-phase comparison (R2 R5 and whatever the current scenario tags)
  always @(posedge cpu_clk) begin
    #(CPU_P/4);
    cpu_g = (cpu_hist.size() > 1) ? cpu_hist[$-1] : '0;
    check(req_tag, "cpu_t high phase", 32'(cpu_t), 32'(cpu_g));
    check("R5", "cpu pair complement", 32'(cpu_t ^ cpu_c), 32'({N_CPU{1'b1}}));
  end
  always @(negedge cpu_clk) begin
    #(CPU_P/4);
    check(req_tag, "cpu_t low phase", 32'(cpu_t), 32'h0);
    check("R5", "cpu_c low phase", 32'(cpu_c), 32'({N_CPU{1'b1}}));
  end
  always @(posedge pci_clk) begin
    #(PCI_P/4);
    pci_g = (pci_hist.size() > 1) ? pci_hist[$-1] : '0;
    pcf_g = (pcf_hist.size() > 1) ? pcf_hist[$-1] : 1'b0;
    check(req_tag, "pci high phase", 32'(pci_o), 32'(pci_g));
    check(req_tag, "pci_free high phase", 32'(pci_free), 32'(pcf_g));
  end
  always @(negedge pci_clk) begin
    #(PCI_P/4);
    check(req_tag, "pci low phase", 32'({pci_free, pci_o}), 32'h0);
  end
  always @(posedge agp_clk) begin
    #(AGP_P/4);
    agp_g = (agp_hist.size() > 1) ? agp_hist[$-1] : '0;
    check(req_tag, "agp high phase", 32'(agp_o), 32'(agp_g));
  end
  always @(negedge agp_clk) begin
    #(AGP_P/4);
    check(req_tag, "agp low phase", 32'(agp_o), 32'h0);
  end
  always @(posedge ref_clk) begin
    #(REF_P/4);
    ref_g = (ref_hist.size() > 1) ? ref_hist[$-1] : '0;
    check(req_tag, "ref high phase", 32'(ref_o), 32'(ref_g));
  end
  always @(negedge ref_clk) begin
    #(REF_P/4);
    check(req_tag, "ref low phase", 32'(ref_o), 32'h0);
  end
  always @(posedge fix_clk) begin
    #(FIX_P/4);
    fix_g = (fix_hist.size() > 1) ? fix_hist[$-1] : '0;
    check(req_tag, "fix high phase", 32'(fix_o), 32'(fix_g));
  end
  always @(negedge fix_clk) begin
    #(FIX_P/4);
    check(req_tag, "fix low phase", 32'(fix_o), 32'h0);
  end

  // R3: full-width pulses
  realtime t_cpu_rise = 0.0, t_pci_rise = 0.0;
  always @(posedge cpu_t[0]) t_cpu_rise = $realtime;
  always @(negedge cpu_t[0])
    check("R3", "cpu_t pulse width", 32'(int'($realtime - t_cpu_rise)), 32'(CPU_P/2));
  always @(posedge pci_o[0]) t_pci_rise = $realtime;
  always @(negedge pci_o[0])
    check("R3", "pci pulse width", 32'(int'($realtime - t_pci_rise)), 32'(PCI_P/2));

  task automatic cpu_cycles(int n);
    repeat (n) @(posedge cpu_clk);
    #1;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(WATCHDOG);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int cnt;
    int first;
    // R1 reset state
    req_tag = "R1";
    cpu_cycles(5);
    check("R1", "cpu_t in reset", 32'(cpu_t), 32'h0);
    check("R1", "cpu_c in reset", 32'(cpu_c), 32'({N_CPU{1'b1}}));
    check("R1", "others in reset", 32'({pci_free, pci_o, agp_o, ref_o, fix_o}), 32'h0);
    rst_ni = 1'b1;
    req_tag = "R2";
    cpu_cycles(30);

    // R4 stop latency and park, R8 isolation
    req_tag = "R4";
    cpu_stop_n = 1'b0;
    cnt = 0;
    repeat (6) begin @(posedge cpu_clk); #(CPU_P/4); if (cpu_t[0]) cnt++; end
    check("R4", "cpu pulses after stop", 32'(cnt), 32'd1);
    check("R4", "cpu_c parked high", 32'(cpu_c), 32'({N_CPU{1'b1}}));
    req_tag = "R8";
    cnt = 0;
    repeat (4) begin @(posedge pci_clk); #(PCI_P/4); if (pci_o[0]) cnt++; end
    check("R8", "pci runs during cpu stop", 32'(cnt), 32'd4);
    req_tag = "R4";
    cpu_cycles(1);
    cpu_stop_n = 1'b1;
    first = 0;
    for (int i = 1; i <= 6; i++) begin
      @(posedge cpu_clk); #(CPU_P/4);
      if (cpu_t[0] && first == 0) first = i;
    end
    check("R4", "cpu restart edge", 32'(first), 32'd2);
    cpu_cycles(10);

    // R6 pci stop, R7 free-running and other groups
    req_tag = "R6";
    @(posedge pci_clk); #1;
    pci_stop_n = 1'b0;
    cnt = 0;
    first = 0;
    repeat (4) begin
      @(posedge pci_clk); #(PCI_P/4);
      if (pci_o[0]) cnt++;
      if (pci_free) first++;
    end
    check("R6", "pci pulses after stop", 32'(cnt), 32'd1);
    check("R7", "pci_free during pci stop", 32'(first), 32'd4);
    req_tag = "R7";
    cpu_stop_n = 1'b0;
    cpu_cycles(40);
    cpu_stop_n = 1'b1;
    req_tag = "R6";
    @(posedge pci_clk); #1;
    pci_stop_n = 1'b1;
    first = 0;
    for (int i = 1; i <= 4; i++) begin
      @(posedge pci_clk); #(PCI_P/4);
      if (pci_o[0] && first == 0) first = i;
    end
    check("R6", "pci restart edge", 32'(first), 32'd2);

    // R10 per-output enables
    req_tag = "R10";
    cpu_en = 3'b101; pci_en = 7'b0101010; agp_en = 2'b01; ref_en = 2'b10; fix_en = 2'b01;
    cpu_cycles(60);
    cnt = 0;
    repeat (4) begin @(posedge cpu_clk); #(CPU_P/4); if (cpu_t[1] || !cpu_t[0]) cnt++; end
    check("R10", "only pair 1 disabled", 32'(cnt), 32'd0);
    cpu_en = '1; pci_en = '1; agp_en = '1; ref_en = '1; fix_en = '1;
    cpu_cycles(30);

    // R9 power-down, R11 inputs ignored meanwhile
    req_tag = "R9";
    pd_n = 1'b0;
    cnt = 0;
    repeat (6) begin @(posedge cpu_clk); #(CPU_P/4); if (cpu_t[0]) cnt++; end
    check("R9", "cpu pulses after power-down", 32'(cnt), 32'd1);
    cpu_cycles(20);
    req_tag = "R11";
    cpu_stop_n = 1'b0; pci_stop_n = 1'b0; cpu_en = 3'b010; pci_en = 7'h0f;
    cpu_cycles(20);
    cpu_stop_n = 1'b1; pci_stop_n = 1'b1; cpu_en = '1; pci_en = '1;
    cpu_cycles(40);
    check("R9", "all low in power-down",
          32'({pci_free, pci_o, agp_o, ref_o, fix_o, cpu_t}), 32'h0);
    check("R9", "cpu_c high in power-down", 32'(cpu_c), 32'({N_CPU{1'b1}}));
    cpu_stop_n = 1'b0;
    pd_n = 1'b1;
    cpu_cycles(30);
    cnt = 0;
    first = 0;
    repeat (4) begin
      @(posedge pci_clk); #(PCI_P/4);
      if (pci_o[0]) cnt++;
      if (cpu_t != '0) first++;
    end
    check("R11", "pci resumes after power-down", 32'(cnt), 32'd4);
    check("R11", "cpu held by its stop after power-down", 32'(first), 32'd0);
    cpu_stop_n = 1'b1;
    req_tag = "R2";
    cpu_cycles(30);
    finish_run();
  end
endmodule